// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a fast oscillator clock into the bit timing of a CAN node. A prescaler makes a time-quantum tick. A segment sequencer splits every bit into a one-quantum sync segment, a first time segment (propagation plus phase 1) and a second phase segment. It raises a one-clock sample strobe at the end of phase 1 and a one-clock bit-boundary strobe at the end of phase 2.

Every timing field is written as its length minus one. The second phase segment either comes from its own field or is derived from phase 1. Sampling is single or a three-way majority vote. A recessive-to-dominant edge pulse, supplied by logic outside this block, either restarts the bit (hard sync) or shifts the sample point (resynchronization), bounded by the jump width.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_tick` is high for one clock out of every 2*(`prescale`+1) clocks and is never high in two consecutive clocks.
- R2: While `rst_n` is low, `tq_tick`, `sample_strobe` and `bit_boundary` are 0, `rx_bit` is 1, and the bit starts in its sync quantum.
- R3: With no edges, a bit lasts 1 + (`prop_len`+1) + (`ps1_len`+1) + PS2 quanta. `sample_strobe` comes with the tick that ends quantum 1+(`prop_len`+1)+(`ps1_len`+1) of the bit, and `bit_boundary` comes with the tick that ends its last quantum.
- R4: PS2 is `ps2_len`+1 quanta when `ps2_from_field`=1, and max(`ps1_len`+1, 2) quanta when `ps2_from_field`=0.
- R5: With `triple_sample`=0, `rx_bit` takes the value of `rx_level` in the sample-strobe clock and holds it at all other times.
- R6: With `triple_sample`=1, `rx_bit` takes the majority of `rx_level` at the sample tick and at the two ticks before it.
- R7: A `rx_edge` pulse with `hard_sync_en`=1 suppresses that clock's tick and restarts the quantum and the bit. The next tick comes 2*(`prescale`+1) clocks after the edge clock and ends the sync quantum, so the next boundary falls one nominal bit after the edge.
- R8: A resync edge (`hard_sync_en`=0) that arrives in the sync quantum has no effect on the bit timing.
- R9: A resync edge that arrives in quantum c (counted from 0) of the first time segment lengthens that segment by min(c+1, `sjw_len`+1) quanta. An edge is applied before the tick of its own clock.
- R10: A resync edge that arrives in quantum c of PS2 shortens PS2 by min(PS2-c-1, `sjw_len`+1) quanta, so an edge in the last quantum of PS2 has no effect.
- R11: Only the first resync edge of a bit acts. Later edges in the same bit are ignored until the bit boundary or a hard sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prescale | input | 6 | Quantum prescaler; quantum = 2*(value+1) clocks |
| sjw_len | input | 2 | Jump width minus one, in quanta |
| prop_len | input | 3 | Propagation segment length minus one |
| ps1_len | input | 3 | Phase segment 1 length minus one |
| ps2_len | input | 3 | Phase segment 2 length minus one |
| ps2_from_field | input | 1 | 1: PS2 from `ps2_len`; 0: PS2 derived from phase 1 |
| triple_sample | input | 1 | 1: majority of three samples; 0: single sample |
| hard_sync_en | input | 1 | 1: edges restart the bit; 0: edges resynchronize |
| rx_edge | input | 1 | One-clock pulse for a recessive-to-dominant bus edge |
| rx_level | input | 1 | Bus level |
| tq_tick | output | 1 | One-clock pulse at the end of each quantum |
| sample_strobe | output | 1 | One-clock pulse at the sample point |
| bit_boundary | output | 1 | One-clock pulse at the end of a bit |
| rx_bit | output | 1 | Sampled bus value |

## Verification
The bench places resync edges in the sync quantum, in the first and last quanta of each segment, and twice within one bit. A design that miscounts the phase error would move the boundary by one quantum. A design that ignores the jump width cap would stretch or cut a bit by more than the jump width. A design that resynchronizes twice would shift the sample point a second time. It also covers the derived-PS2 floor of two quanta: getting it wrong yields a one-quantum PS2 and a short bit. In triple mode, a sampler that takes the wrong ticks or the wrong vote shows up as an `rx_bit` mismatch under random bus noise. Hard syncs taken mid-quantum check that the prescaler restarts rather than finishing its count.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_T1   = 2'd1,
    SEG_T2   = 2'd2
  } seg_e;

  // Oscillator clocks per time quantum.
  function automatic int quantum_clocks(int presc);
    return 2 * (presc + 1);
  endfunction

  // Propagation plus phase 1, in quanta.
  function automatic int tseg1_quanta(int prop, int ps1);
    return (prop + 1) + (ps1 + 1);
  endfunction

  // Phase 2 in quanta: own field, or the larger of phase 1 and two.
  function automatic int ps2_quanta(int ps1, int ps2, logic from_field);
    if (from_field) return ps2 + 1;
    return (ps1 + 1 > 2) ? ps1 + 1 : 2;
  endfunction

  function automatic int sjw_quanta(int sjw);
    return sjw + 1;
  endfunction

  function automatic logic majority3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler
  import cbt_pkg::*;
#(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] presc,
  input  logic             restart,
  output logic             tick
);
  localparam int CW = BRP_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = CW'(quantum_clocks(int'(presc)) - 1);
  assign tick = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + CW'(1);
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R7
  restart_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

endmodule

// File: rtl/cbt_bitseq.sv
module cbt_bitseq
  import cbt_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             resync_edge,
  input  logic             hard_sync,
  input  logic [CNT_W-1:0] t1_q,
  input  logic [CNT_W-1:0] p2_q,
  input  logic [CNT_W-1:0] sj_q,
  output logic             sample_pt,
  output logic             bit_end
);
  seg_e             seg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ext;
  logic [CNT_W-1:0] shr;
  logic             synced;

  logic             in_t1, in_t2, rs_t1, rs_t2;
  logic [CNT_W-1:0] step, remain, ext_eff, shr_eff, t1_lim, t2_lim;

  always_comb begin
    in_t1   = (seg == SEG_T1);
    in_t2   = (seg == SEG_T2);
    rs_t1   = resync_edge && in_t1 && !synced;
    rs_t2   = resync_edge && in_t2 && !synced;
    step    = cnt + CNT_W'(1);
    remain  = p2_q - step;
    ext_eff = rs_t1 ? ((step < sj_q) ? step : sj_q) : ext;
    shr_eff = rs_t2 ? ((remain < sj_q) ? remain : sj_q) : shr;
    t1_lim  = t1_q + ext_eff;
    t2_lim  = p2_q - shr_eff;
    sample_pt = tick && in_t1 && (step == t1_lim);
    bit_end   = tick && in_t2 && (step == t2_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg <= SEG_SYNC; cnt <= '0; ext <= '0; shr <= '0; synced <= 1'b0;
    end else if (hard_sync) begin
      seg <= SEG_SYNC; cnt <= '0; ext <= '0; shr <= '0; synced <= 1'b0;
    end else begin
      if (rs_t1 || rs_t2) begin
        synced <= 1'b1;
        ext    <= ext_eff;
        shr    <= shr_eff;
      end
      if (tick) begin
        case (seg)
          SEG_SYNC: begin seg <= SEG_T1; cnt <= '0; end
          SEG_T1: begin
            if (sample_pt) begin seg <= SEG_T2; cnt <= '0; end
            else cnt <= step;
          end
          SEG_T2: begin
            if (bit_end) begin
              seg <= SEG_SYNC; cnt <= '0; ext <= '0; shr <= '0; synced <= 1'b0;
            end else cnt <= step;
          end
          default: seg <= SEG_SYNC;
        endcase
      end
    end
  end

  // Checker state: quanta counted since the last boundary.
  logic [CNT_W-1:0] qcount;
  logic             full_bit;
  logic [CNT_W-1:0] nominal;
  assign nominal = t1_q + p2_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcount <= '0; full_bit <= 1'b0;
    end else if (hard_sync) begin
      qcount <= '0; full_bit <= 1'b0;
    end else if (bit_end) begin
      qcount <= '0; full_bit <= 1'b1;
    end else if (tick) begin
      qcount <= qcount + CNT_W'(1);
    end
  end

  // R3
  nominal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && full_bit && !(synced || rs_t1 || rs_t2))
      |-> ((qcount + CNT_W'(1)) == nominal));

  // R10
  resync_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && full_bit && (synced || rs_t1 || rs_t2))
      |-> (((qcount + CNT_W'(1)) >= (nominal - sj_q)) &&
           ((qcount + CNT_W'(1)) <= (nominal + sj_q))));

  // R8
  sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_SYNC && resync_edge && !hard_sync) |=> (ext == '0 && shr == '0));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pt |=> !bit_end);

endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler
  import cbt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sample_pt,
  input  logic triple,
  input  logic rx,
  output logic bit_val
);
  logic [1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= 2'b11;
      bit_val <= 1'b1;
    end else begin
      if (tick) hist <= {hist[0], rx};
      if (sample_pt) bit_val <= triple ? majority3(rx, hist[0], hist[1]) : rx;
    end
  end

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_pt |=> $stable(bit_val));

  // R6
  triple_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && triple && (rx == hist[0])) |=> (bit_val == $past(rx)));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import cbt_pkg::*;
#(
  parameter int BRP_W = 6,
  parameter int SJW_W = 2,
  parameter int SEG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] prescale,
  input  logic [SJW_W-1:0] sjw_len,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ps1_len,
  input  logic [SEG_W-1:0] ps2_len,
  input  logic             ps2_from_field,
  input  logic             triple_sample,
  input  logic             hard_sync_en,
  input  logic             rx_edge,
  input  logic             rx_level,
  output logic             tq_tick,
  output logic             sample_strobe,
  output logic             bit_boundary,
  output logic             rx_bit
);
  localparam int CNT_W = SEG_W + 3;

  logic             raw_tick, hard, resync;
  logic [CNT_W-1:0] t1_q, p2_q, sj_q;

  assign hard    = rx_edge & hard_sync_en;
  assign resync  = rx_edge & ~hard_sync_en;
  assign tq_tick = raw_tick & ~hard;

  assign t1_q = CNT_W'(tseg1_quanta(int'(prop_len), int'(ps1_len)));
  assign p2_q = CNT_W'(ps2_quanta(int'(ps1_len), int'(ps2_len), ps2_from_field));
  assign sj_q = CNT_W'(sjw_quanta(int'(sjw_len)));

  cbt_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .presc(prescale), .restart(hard), .tick(raw_tick)
  );

  cbt_bitseq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tq_tick), .resync_edge(resync),
    .hard_sync(hard), .t1_q(t1_q), .p2_q(p2_q), .sj_q(sj_q),
    .sample_pt(sample_strobe), .bit_end(bit_boundary)
  );

  cbt_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .tick(tq_tick), .sample_pt(sample_strobe),
    .triple(triple_sample), .rx(rx_level), .bit_val(rx_bit)
  );

endmodule

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] prescale = '0;
  logic [1:0] sjw_len = '0;
  logic [2:0] prop_len = '0, ps1_len = '0, ps2_len = '0;
  logic       ps2_from_field = 1'b1, triple_sample = 1'b0, hard_sync_en = 1'b0;
  logic       rx_edge = 1'b0, rx_level = 1'b1;
  logic       tq_tick, sample_strobe, bit_boundary, rx_bit;

  always #5 clk = ~clk;

  can_bit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .sjw_len(sjw_len),
    .prop_len(prop_len), .ps1_len(ps1_len), .ps2_len(ps2_len),
    .ps2_from_field(ps2_from_field), .triple_sample(triple_sample),
    .hard_sync_en(hard_sync_en), .rx_edge(rx_edge), .rx_level(rx_level),
    .tq_tick(tq_tick), .sample_strobe(sample_strobe),
    .bit_boundary(bit_boundary), .rx_bit(rx_bit)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // Behavioural reference state: position in bit measured in quanta.
  int   m_clk, m_pos, m_ext, m_shr;
  bit   m_done;
  logic m_h1, m_h2, m_bit;

  int   cyc, last_b, last_len, last_t, tick_gap, hard_cyc;
  bit   saw_b, saw_s, hard_pend;
  string tag;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int qlen();
    return 2 * (int'(prescale) + 1);
  endfunction

  function automatic int ps2q();
    if (ps2_from_field) return int'(ps2_len) + 1;
    return (int'(ps1_len) + 1 > 2) ? int'(ps1_len) + 1 : 2;
  endfunction

  function automatic int nom_quanta();
    return 1 + (int'(prop_len) + 1) + (int'(ps1_len) + 1) + ps2q();
  endfunction

  task automatic model_step(output bit et, output bit es, output bit eb);
    int t1, p2, sj, c, end1;
    bit hard, in1, in2;
    t1 = int'(prop_len) + int'(ps1_len) + 2;
    p2 = ps2q();
    sj = int'(sjw_len) + 1;
    hard = rx_edge && hard_sync_en;
    et = (m_clk == qlen() - 1) && !hard;
    es = 1'b0; eb = 1'b0;
    if (hard) begin
      m_clk = 0; m_pos = 0; m_ext = 0; m_shr = 0; m_done = 1'b0;
    end else begin
      end1 = t1 + m_ext;
      in1 = (m_pos >= 1) && (m_pos <= end1);
      in2 = (m_pos > end1);
      if (rx_edge && !m_done && in1) begin
        c = m_pos - 1;
        m_ext = (c + 1 < sj) ? c + 1 : sj;
        m_done = 1'b1;
      end else if (rx_edge && !m_done && in2) begin
        c = m_pos - end1 - 1;
        m_shr = (p2 - c - 1 < sj) ? p2 - c - 1 : sj;
        m_done = 1'b1;
      end
      if (et) begin
        es = in1 && (m_pos == t1 + m_ext);
        eb = in2 && (m_pos - t1 - m_ext == p2 - m_shr);
        if (es) begin
          if (triple_sample)
            m_bit = (rx_level & m_h1) | (rx_level & m_h2) | (m_h1 & m_h2);
          else
            m_bit = rx_level;
        end
        m_h2 = m_h1; m_h1 = rx_level;
        if (eb) begin m_pos = 0; m_ext = 0; m_shr = 0; m_done = 1'b0; end
        else m_pos++;
        m_clk = 0;
      end else begin
        m_clk++;
      end
    end
  endtask

  task automatic one_cycle(bit e);
    bit et, es, eb;
    logic pb;
    rx_edge  = e;
    rx_level = lfsr[0];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1;
    pb = m_bit;
    model_step(et, es, eb);
    chk(hard_sync_en ? "R7" : "R1", int'(tq_tick), int'(et));
    chk(tag, int'(sample_strobe), int'(es));
    chk(tag, int'(bit_boundary), int'(eb));
    chk(triple_sample ? "R6" : "R5", int'(rx_bit), int'(pb));
    if (bit_boundary) begin
      if (last_b >= 0) last_len = cyc - last_b;
      last_b = cyc; saw_b = 1'b1;
    end
    if (sample_strobe) saw_s = 1'b1;
    if (tq_tick) begin
      if (last_t >= 0) tick_gap = cyc - last_t;
      last_t = cyc;
    end
    if (e && hard_sync_en) begin
      hard_cyc = cyc; hard_pend = 1'b1;
    end else if (hard_pend && tq_tick) begin
      chk("R7", cyc - hard_cyc, qlen());
      hard_pend = 1'b0;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) one_cycle(1'b0);
  endtask

  task automatic wait_b();
    saw_b = 1'b0;
    while (!saw_b) one_cycle(1'b0);
  endtask

  task automatic wait_s();
    saw_s = 1'b0;
    while (!saw_s) one_cycle(1'b0);
  endtask

  task automatic do_reset(int b, int s, int p, int a, int c, bit own, bit tri3, bit hs);
    @(negedge clk);
    rst_n = 1'b0; rx_edge = 1'b0;
    prescale = 6'(b); sjw_len = 2'(s); prop_len = 3'(p); ps1_len = 3'(a);
    ps2_len = 3'(c); ps2_from_field = own; triple_sample = tri3; hard_sync_en = hs;
    repeat (3) @(negedge clk);
    // R2: outputs while reset is held
    chk("R2", int'(tq_tick), 0);
    chk("R2", int'(sample_strobe), 0);
    chk("R2", int'(bit_boundary), 0);
    chk("R2", int'(rx_bit), 1);
    m_clk = 0; m_pos = 0; m_ext = 0; m_shr = 0; m_done = 1'b0;
    m_h1 = 1'b1; m_h2 = 1'b1; m_bit = 1'b1;
    last_b = -1; last_len = -1; last_t = -1; tick_gap = -1; hard_pend = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    cyc = 0;
    tag = "R3";
    // Nominal bit: 1+2+3+4 = 10 quanta of 4 clocks.
    do_reset(1, 1, 1, 2, 3, 1'b1, 1'b0, 1'b0);
    wait_b(); wait_b();
    chk("R3", last_len, 40);
    chk("R1", tick_gap, 4);

    tag = "R8";
    wait_b(); one_cycle(1'b1); wait_b();
    chk("R8", last_len, 40);

    tag = "R9";
    wait_b(); quiet(4); one_cycle(1'b1); wait_b();
    chk("R9", last_len, 44);
    wait_b(); quiet(20); one_cycle(1'b1); wait_b();
    chk("R9", last_len, 48);

    tag = "R10";
    wait_b(); wait_s(); one_cycle(1'b1); wait_b();
    chk("R10", last_len, 32);
    wait_b(); wait_s(); quiet(12); one_cycle(1'b1); wait_b();
    chk("R10", last_len, 40);

    tag = "R11";
    wait_b(); quiet(4); one_cycle(1'b1); wait_s(); one_cycle(1'b1); wait_b();
    chk("R11", last_len, 44);

    tag = "R7";
    do_reset(1, 1, 1, 2, 3, 1'b1, 1'b0, 1'b1);
    wait_b(); quiet(7); one_cycle(1'b1); wait_b();
    chk("R7", last_b - hard_cyc, 40);

    tag = "R4";
    do_reset(0, 0, 0, 0, 5, 1'b0, 1'b0, 1'b0);
    wait_b(); wait_b();
    chk("R4", last_len, 10);
    do_reset(0, 0, 0, 4, 0, 1'b0, 1'b0, 1'b0);
    wait_b(); wait_b();
    chk("R4", last_len, 24);
    tag = "R3";
    do_reset(2, 3, 3, 1, 7, 1'b1, 1'b0, 1'b0);
    wait_b(); wait_b();
    chk("R3", last_len, qlen() * nom_quanta());
    chk("R1", tick_gap, 6);

    // Random edges and bus noise across several settings.
    for (int k = 0; k < 6; k++) begin
      tag = (k % 2 == 0) ? "R9" : "R10";
      do_reset(k, k % 4, (k * 3) % 8, (k * 5) % 8, (k * 7) % 8,
               1'(k % 2), 1'((k / 2) % 2), 1'(k == 5));
      for (int i = 0; i < 2500; i++) one_cycle(lfsr[7:3] == 5'd0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule